// File: doc/BRIEF.md
# LCD Panel Power and Configuration Sequencer

This block powers a small TFT panel up and down and loads its configuration over a write-only serial link. A one-cycle enable strobe turns on the panel supply. The block waits for the supply to settle, releases the active-low panel reset and then sends a fixed script of twenty register writes. A disable strobe runs the shutdown script in reverse order: a partial standby write, reset asserted, a frame-length wait, a full standby write and finally the supply off. While the panel is up, a gamma strobe replays only the gamma writes with fresh values.

Each write is one 16-bit word sent in SPI mode 0. The six-bit register address is carried at the top of the word, followed by a zero bit, a one bit that marks a write, and the data byte. Millisecond delays come from a prescaler derived from the system clock frequency parameter. A testbench can therefore shrink them by lowering that parameter. Integrators that want the panel's usual settings drive mode 7 and the default gamma curve provided by `lcd_seq_pkg::dflt_gamma()`.

Top module: `lcd_pwr_seq`

## Requirements
- R1: Every write is a single 16-bit word sent MSB first within one `cs_n` low period. `sclk` idles low and `mosi` is stable while `sclk` is high, so the receiver samples on the rising edge. The word is {addr[5:0], 1'b0, 1'b1, data[7:0]}.
- R2: An accepted enable raises `supply_en` on the next cycle. `panel_rst_n` rises no less than UP_MS milliseconds (UP_MS×CLK_HZ/1000 cycles) and at most 4 cycles later than that, and before the first word starts. `panel_rst_n` is never high while `supply_en` is low.
- R3: The power-up words are sent in this order: addr 0x02 with data {5'b00001, mode}, addr 0x03 with 0xDF, addr 0x20 with 0xF0, addr 0x21 with 0xF0, addr 0x04 with the mirror byte, and then the fifteen gamma words (twenty words in all).
- R4: The mirror byte is 0x17 with bit 0 cleared when horizontal mirroring is requested and bit 1 cleared when vertical mirroring is requested.
- R5: Addrs 0x11, 0x12 and 0x13 carry bits [9:8] of gamma points 0–3, 4–7 and 8–11. Within each group the lowest-numbered point sits in data bits [7:6], the next in [5:4], then [3:2] and [1:0]. Point i occupies `gamma_i[10i+9:10i]`.
- R6: After the three high-bit words, the low bytes of points 0 to 11 go to addrs 0x14 to 0x1F in ascending order.
- R7: `busy` is high from the cycle after an accepted strobe until its script ends. `active` rises only after the last power-up word completes, and `busy` and `active` are never both high.
- R8: An accepted disable sends addr 0x03 with 0xD8. Once that word ends, `panel_rst_n` drops. At least DOWN_MS milliseconds after that, the block sends addr 0x03 with 0xD0. `supply_en` falls only after that word ends, and the block returns to idle.
- R9: A strobe is ignored in any state that does not take it. This covers enable while active, disable while idle, and any strobe during a running script. An ignored strobe sends no word and leaves `supply_en`, `panel_rst_n` and `active` unchanged. When disable and gamma strobes coincide while active, disable wins.
- R10: A gamma strobe while active sends exactly the fifteen gamma words (0x11 to 0x1F, as R5 and R6) and returns to active. A gamma strobe while not active is ignored.
- R11: After reset: `supply_en`=0, `panel_rst_n`=0, `cs_n`=1, `sclk`=0, `busy`=0, `active`=0.
- R12: Mode, mirror bits and gamma values are captured when the enable is accepted. For a gamma replay, only the gamma values are captured when its strobe is accepted. Input changes during a script do not alter the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Power-up strobe, one cycle |
| dis_req | input | 1 | Shutdown strobe, one cycle |
| gam_req | input | 1 | Gamma replay strobe, one cycle |
| mode_i | input | 3 | Panel mode code for addr 0x02 |
| hmir_i | input | 1 | Horizontal mirror request |
| vmir_i | input | 1 | Vertical mirror request |
| gamma_i | input | 120 | Twelve 10-bit gamma points, point i at bits [10i+9:10i] |
| supply_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low chip select, one word per assertion |
| busy | output | 1 | A script or delay is running |
| active | output | 1 | Panel is up and configured |

## Verification
`supply_en` and `busy` respond on the first clock edge that sees an accepted strobe, and the bench samples them at the falling edge right after the strobe's cycle. The reset release is due UP_MS×CLK_HZ/1000 + 2 cycles after the supply rises, and the first `cs_n` fall comes one cycle after that. The bench does not rely on the exact count: it timestamps each edge and accepts a window of a few cycles above the millisecond bound. It checks the shutdown gap between the `panel_rst_n` fall and the second standby word the same way. Word contents are captured by a monitor on the rising edges of `sclk`, so they are compared whatever the serial divider, and all status checks wait for the settled idle or active state before they sample.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NPTS    = 12;
    localparam int GRP     = 4;
    localparam int NGRP    = NPTS / GRP;
    localparam int FRM_W   = 16;
    localparam int STEP_W  = 5;

    // script step numbering
    localparam int STEP_MODE = 0;
    localparam int STEP_GHI  = 5;
    localparam int STEP_GLO  = STEP_GHI + NGRP;
    localparam int STEP_LAST = STEP_GLO + NPTS - 1;
    localparam int STEP_DN_A = STEP_LAST + 1;
    localparam int STEP_DN_B = STEP_LAST + 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PWR_WAIT,
        S_UP_SEND,
        S_ACTIVE,
        S_DN_SEND1,
        S_DN_WAIT,
        S_DN_SEND2
    } seq_st_e;

    function automatic logic [FRM_W-1:0] mk_frame(input logic [5:0] addr,
                                                  input logic [7:0] data);
        return {addr, 2'b01, data};
    endfunction

    // usual panel curve, point i at [10i+9:10i]
    function automatic logic [NPTS*10-1:0] dflt_gamma();
        logic [NPTS*10-1:0] v;
        v = {10'd1020, 10'd942, 10'd864, 10'd785, 10'd705, 10'd625,
             10'd543, 10'd460, 10'd375, 10'd289, 10'd200, 10'd106};
        return v;
    endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MS_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [MS_W-1:0] ms_i,
    output logic            done_o
);
    localparam int TICK  = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 2;
    localparam int PRE_W = $clog2(TICK);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [MS_W-1:0]  ms;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.pre = '0;
            tmr_d.ms  = ms_i;
        end else if (tmr_q.run) begin
            if (tmr_q.pre == PRE_W'(TICK - 1)) begin
                tmr_d.pre = '0;
                if (tmr_q.ms <= MS_W'(1)) begin
                    tmr_d.run  = 1'b0;
                    tmr_d.done = 1'b1;
                end else begin
                    tmr_d.ms = tmr_q.ms - 1'b1;
                end
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.done;

    // R2
    tmr_done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.done |-> ($past(tmr_q.run) && !tmr_q.run));

endmodule

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
    parameter int DIV = 4,
    parameter int W   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] word_i,
    output logic         sclk_o,
    output logic         mosi_o,
    output logic         cs_n_o,
    output logic         done_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW = $clog2(W);

    typedef struct packed {
        logic          busy;
        logic          tail;
        logic          sclk;
        logic [W-1:0]  sh;
        logic [BW-1:0] bitc;
        logic [DW-1:0] div;
        logic          done;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        if (!tx_q.busy) begin
            if (start_i) begin
                tx_d.busy = 1'b1;
                tx_d.tail = 1'b0;
                tx_d.sclk = 1'b0;
                tx_d.sh   = word_i;
                tx_d.bitc = '0;
                tx_d.div  = '0;
            end
        end else if (tx_q.div != DW'(DIV - 1)) begin
            tx_d.div = tx_q.div + 1'b1;
        end else begin
            tx_d.div = '0;
            if (tx_q.tail) begin
                tx_d.busy = 1'b0;
                tx_d.done = 1'b1;
            end else if (!tx_q.sclk) begin
                tx_d.sclk = 1'b1;
            end else begin
                tx_d.sclk = 1'b0;
                if (tx_q.bitc == BW'(W - 1)) begin
                    tx_d.tail = 1'b1;
                end else begin
                    tx_d.bitc = tx_q.bitc + 1'b1;
                    tx_d.sh   = {tx_q.sh[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sclk_o = tx_q.sclk;
    assign mosi_o = tx_q.sh[W-1];
    assign cs_n_o = ~tx_q.busy;
    assign done_o = tx_q.done;

    // R1
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.sclk && $past(tx_q.sclk)) |-> $stable(tx_q.sh[W-1]));

    // R1
    one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.done |-> ($past(tx_q.tail) && $past(tx_q.bitc) == BW'(W - 1)));

endmodule

// File: rtl/lcd_cfg_script.sv
module lcd_cfg_script
    import lcd_seq_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic [STEP_W-1:0]  step_i,
    input  logic [2:0]         mode_i,
    input  logic               hmir_i,
    input  logic               vmir_i,
    input  logic [NPTS*GW-1:0] gamma_i,
    output logic [FRM_W-1:0]   frame_o
);
    logic [NGRP-1:0][7:0] hi_byte;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar p = 0; p < GRP; p++) begin : g_pt
            assign hi_byte[g][7-2*p -: 2] = gamma_i[(GRP*g+p)*GW + GW-2 +: 2];
        end
    end

    always_comb begin
        frame_o = mk_frame(6'h03, 8'hD0);
        if (step_i == STEP_W'(STEP_MODE)) begin
            frame_o = mk_frame(6'h02, {5'b00001, mode_i});
        end else if (step_i == STEP_W'(1)) begin
            frame_o = mk_frame(6'h03, 8'hDF);
        end else if (step_i == STEP_W'(2)) begin
            frame_o = mk_frame(6'h20, 8'hF0);
        end else if (step_i == STEP_W'(3)) begin
            frame_o = mk_frame(6'h21, 8'hF0);
        end else if (step_i == STEP_W'(4)) begin
            frame_o = mk_frame(6'h04, {3'b000, 1'b1, 1'b0, 1'b1, ~vmir_i, ~hmir_i});
        end else if (step_i == STEP_W'(STEP_DN_A)) begin
            frame_o = mk_frame(6'h03, 8'hD8);
        end
        for (int g = 0; g < NGRP; g++) begin
            if (step_i == STEP_W'(STEP_GHI + g))
                frame_o = mk_frame(6'(8'h11 + g), hi_byte[g]);
        end
        for (int i = 0; i < NPTS; i++) begin
            if (step_i == STEP_W'(STEP_GLO + i))
                frame_o = mk_frame(6'(8'h14 + i), gamma_i[i*GW +: 8]);
        end
    end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SCLK_DIV = 4,
    parameter int UP_MS    = 160,
    parameter int DOWN_MS  = 50,
    parameter int GW       = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_req,
    input  logic               dis_req,
    input  logic               gam_req,
    input  logic [2:0]         mode_i,
    input  logic               hmir_i,
    input  logic               vmir_i,
    input  logic [NPTS*GW-1:0] gamma_i,
    output logic               supply_en,
    output logic               panel_rst_n,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               busy,
    output logic               active
);
    localparam int MS_MAX = (UP_MS > DOWN_MS) ? UP_MS : DOWN_MS;
    localparam int MS_W   = $clog2(MS_MAX + 1);

    typedef struct packed {
        seq_st_e             st;
        logic [STEP_W-1:0]   step;
        logic                kick;
        logic                tstart;
        logic                supply;
        logic                prst;
        logic [2:0]          mode;
        logic                hmir;
        logic                vmir;
        logic [NPTS*GW-1:0]  gam;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_done;
    logic             tx_done;
    logic [MS_W-1:0]  ms_sel;
    logic [FRM_W-1:0] frame;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.kick   = 1'b0;
        ctl_d.tstart = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: if (en_req) begin
                ctl_d.st     = S_PWR_WAIT;
                ctl_d.supply = 1'b1;
                ctl_d.tstart = 1'b1;
                ctl_d.mode   = mode_i;
                ctl_d.hmir   = hmir_i;
                ctl_d.vmir   = vmir_i;
                ctl_d.gam    = gamma_i;
            end
            S_PWR_WAIT: if (tmr_done) begin
                ctl_d.prst = 1'b1;
                ctl_d.st   = S_UP_SEND;
                ctl_d.step = STEP_W'(STEP_MODE);
                ctl_d.kick = 1'b1;
            end
            S_UP_SEND: if (tx_done) begin
                if (ctl_q.step == STEP_W'(STEP_LAST)) begin
                    ctl_d.st = S_ACTIVE;
                end else begin
                    ctl_d.step = ctl_q.step + 1'b1;
                    ctl_d.kick = 1'b1;
                end
            end
            S_ACTIVE: begin
                if (dis_req) begin
                    ctl_d.st   = S_DN_SEND1;
                    ctl_d.step = STEP_W'(STEP_DN_A);
                    ctl_d.kick = 1'b1;
                end else if (gam_req) begin
                    ctl_d.gam  = gamma_i;
                    ctl_d.st   = S_UP_SEND;
                    ctl_d.step = STEP_W'(STEP_GHI);
                    ctl_d.kick = 1'b1;
                end
            end
            S_DN_SEND1: if (tx_done) begin
                ctl_d.prst   = 1'b0;
                ctl_d.st     = S_DN_WAIT;
                ctl_d.tstart = 1'b1;
            end
            S_DN_WAIT: if (tmr_done) begin
                ctl_d.st   = S_DN_SEND2;
                ctl_d.step = STEP_W'(STEP_DN_B);
                ctl_d.kick = 1'b1;
            end
            S_DN_SEND2: if (tx_done) begin
                ctl_d.supply = 1'b0;
                ctl_d.st     = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= S_IDLE;
        end else begin
            ctl_q      <= ctl_d;
        end
    end

    assign ms_sel = (ctl_q.st == S_DN_WAIT) ? MS_W'(DOWN_MS) : MS_W'(UP_MS);

    lcd_ms_timer #(
        .CLK_HZ (CLK_HZ),
        .MS_W   (MS_W)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ctl_q.tstart),
        .ms_i    (ms_sel),
        .done_o  (tmr_done)
    );

    lcd_cfg_script #(
        .GW (GW)
    ) scr_i (
        .step_i  (ctl_q.step),
        .mode_i  (ctl_q.mode),
        .hmir_i  (ctl_q.hmir),
        .vmir_i  (ctl_q.vmir),
        .gamma_i (ctl_q.gam),
        .frame_o (frame)
    );

    lcd_spi_tx #(
        .DIV (SCLK_DIV),
        .W   (FRM_W)
    ) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ctl_q.kick),
        .word_i  (frame),
        .sclk_o  (sclk),
        .mosi_o  (mosi),
        .cs_n_o  (cs_n),
        .done_o  (tx_done)
    );

    assign supply_en   = ctl_q.supply;
    assign panel_rst_n = ctl_q.prst;
    assign active      = (ctl_q.st == S_ACTIVE);
    assign busy        = (ctl_q.st != S_ACTIVE) && (ctl_q.st != S_IDLE);

    // R2
    rst_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.prst |-> ctl_q.supply);

    // R1
    cs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (ctl_q.supply && ctl_q.prst) || (ctl_q.st == S_DN_SEND2));

    // R7
    active_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(active)) |-> $past(tx_done));

    // R8
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.supply) |-> ($past(tx_done) && !ctl_q.prst));

    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !dis_req && !gam_req) |=> active);

endmodule

// File: tb/lcd_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_pwr_seq_tb_top;
    localparam int CLK_HZ = 20_000;
    localparam int TICK   = CLK_HZ / 1000;
    localparam int UPMS   = 160;
    localparam int DNMS   = 50;
    localparam int NP     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, gam_req = 1'b0;
    logic [2:0] mode_i = 3'd7;
    logic hmir_i = 1'b0, vmir_i = 1'b0;
    logic [NP*10-1:0] gamma_i;
    logic supply_en, panel_rst_n, sclk, mosi, cs_n, busy, active;

    always #2.5 clk = ~clk;

    lcd_pwr_seq #(
        .CLK_HZ(CLK_HZ), .SCLK_DIV(2), .UP_MS(UPMS), .DOWN_MS(DNMS), .GW(10)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .gam_req(gam_req), .mode_i(mode_i), .hmir_i(hmir_i), .vmir_i(vmir_i),
        .gamma_i(gamma_i), .supply_en(supply_en), .panel_rst_n(panel_rst_n),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .active(active)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_en = 1'b0;

    logic [15:0] frm  [256];
    int          fbit [256];
    int          t_csd[256];
    int          t_csu[256];
    int nfr = 0;
    int bitn = 0;
    logic [15:0] shr = '0;
    int t_sup_up = 0, t_sup_dn = 0, t_rst_up = 0, t_rst_dn = 0;

    logic [9:0] gdef [NP];
    logic [9:0] galt [NP];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk) if (mon_en && !cs_n) begin
        shr  = {shr[14:0], mosi};
        bitn = bitn + 1;
    end
    always @(negedge cs_n) if (mon_en) t_csd[nfr] = cyc;
    always @(posedge cs_n) if (mon_en) begin
        frm[nfr]   = shr;
        fbit[nfr]  = bitn;
        t_csu[nfr] = cyc;
        nfr        = nfr + 1;
        bitn       = 0;
    end
    always @(posedge supply_en)   if (mon_en) t_sup_up = cyc;
    always @(negedge supply_en)   if (mon_en) t_sup_dn = cyc;
    always @(posedge panel_rst_n) if (mon_en) t_rst_up = cyc;
    always @(negedge panel_rst_n) if (mon_en) t_rst_dn = cyc;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic load_gamma(input bit alt);
        for (int i = 0; i < NP; i++) gamma_i[i*10 +: 10] = alt ? galt[i] : gdef[i];
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        if (which == 0) en_req = 1'b1;
        else if (which == 1) dis_req = 1'b1;
        else gam_req = 1'b1;
        @(negedge clk);
        en_req = 1'b0; dis_req = 1'b0; gam_req = 1'b0;
    endtask

    task automatic wait_active();
        for (int i = 0; i < 20000; i++) begin
            if (active && !busy) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!active && !busy) break;
            @(negedge clk);
        end
    endtask

    // expected power-up word k (0..19) from the requirements
    function automatic logic [15:0] exp_word(input int k, input logic [2:0] m,
                                             input bit h, input bit v, input bit alt);
        logic [9:0] g [NP];
        logic [7:0] d;
        logic [5:0] a;
        for (int i = 0; i < NP; i++) g[i] = alt ? galt[i] : gdef[i];
        if (k == 0)      begin a = 6'h02; d = 8'h08 | {5'b0, m}; end
        else if (k == 1) begin a = 6'h03; d = 8'hDF; end
        else if (k == 2) begin a = 6'h20; d = 8'hF0; end
        else if (k == 3) begin a = 6'h21; d = 8'hF0; end
        else if (k == 4) begin a = 6'h04; d = 8'h17 & ~{6'b0, v, h}; end
        else if (k < 8)  begin
            a = 6'h11 + 6'(k - 5);
            d = {g[4*(k-5)][9:8], g[4*(k-5)+1][9:8], g[4*(k-5)+2][9:8], g[4*(k-5)+3][9:8]};
        end else begin
            a = 6'h14 + 6'(k - 8);
            d = g[k-8][7:0];
        end
        return {a, 2'b01, d};
    endfunction

    function automatic string tag_of(input int k);
        if (k < 5) return (k == 4) ? "R4 mirror word" : "R3 script order";
        if (k < 8) return "R5 gamma high bits";
        return "R6 gamma low bytes";
    endfunction

    // vector: {alt, v, h, mode[2:0]}
    localparam logic [5:0] VEC [4] = '{6'b0_0_0_111, 6'b1_1_0_011, 6'b1_0_1_000, 6'b0_1_1_101};

    task automatic power_up_and_check(input logic [2:0] m, input bit h, input bit v,
                                      input bit alt, input bit meddle);
        int fb;
        fb = nfr;
        strobe(0);
        chk(supply_en === 1'b1, "R2 supply on after enable", supply_en, 1);
        chk(busy === 1'b1 && active === 1'b0, "R7 busy during power-up", {busy, active}, 2'b10);
        if (meddle) begin
            mode_i = ~m; hmir_i = ~h; vmir_i = ~v; load_gamma(~alt);
            repeat (5) @(negedge clk);
            strobe(0);
            strobe(1);
            chk(supply_en === 1'b1 && busy === 1'b1, "R9 strobes ignored while busy",
                {supply_en, busy}, 2'b11);
        end
        wait_active();
        chk(nfr - fb == 20, "R3 power-up word count", nfr - fb, 20);
        for (int k = 0; k < 20; k++) begin
            chk(frm[fb+k] === exp_word(k, m, h, v, alt),
                meddle ? "R12 captured config" : tag_of(k), frm[fb+k], exp_word(k, m, h, v, alt));
            chk(fbit[fb+k] == 16, "R1 one 16-bit word per select", fbit[fb+k], 16);
        end
        chk((t_rst_up - t_sup_up) >= UPMS*TICK && (t_rst_up - t_sup_up) <= UPMS*TICK + 4,
            "R2 settle delay", t_rst_up - t_sup_up, UPMS*TICK);
        chk(t_rst_up < t_csd[fb], "R2 reset released before first word", t_rst_up, t_csd[fb]);
        chk(active === 1'b1 && busy === 1'b0 && panel_rst_n === 1'b1,
            "R7 active after last word", {active, busy, panel_rst_n}, 3'b101);
    endtask

    task automatic power_down_and_check();
        int fb;
        fb = nfr;
        strobe(1);
        chk(busy === 1'b1 && active === 1'b0, "R7 busy during shutdown", {busy, active}, 2'b10);
        wait_idle();
        chk(nfr - fb == 2, "R8 shutdown word count", nfr - fb, 2);
        chk(frm[fb] === 16'h0DD8, "R8 first standby word", frm[fb], 16'h0DD8);
        chk(frm[fb+1] === 16'h0DD0, "R8 second standby word", frm[fb+1], 16'h0DD0);
        chk(t_rst_dn >= t_csu[fb], "R8 reset low after first word", t_rst_dn, t_csu[fb]);
        chk((t_csd[fb+1] - t_rst_dn) >= DNMS*TICK, "R8 frame wait", t_csd[fb+1] - t_rst_dn, DNMS*TICK);
        chk(t_sup_dn >= t_csu[fb+1], "R8 supply off after last word", t_sup_dn, t_csu[fb+1]);
        chk(supply_en === 1'b0 && panel_rst_n === 1'b0, "R8 idle outputs",
            {supply_en, panel_rst_n}, 2'b00);
    endtask

    initial begin
        gdef = '{10'd106, 10'd200, 10'd289, 10'd375, 10'd460, 10'd543,
                 10'd625, 10'd705, 10'd785, 10'd864, 10'd942, 10'd1020};
        for (int i = 0; i < NP; i++) galt[i] = 10'(1023 - i*85);
        load_gamma(1'b0);
    end

    initial begin
        int fb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        // R11 reset state
        chk(supply_en === 1'b0 && panel_rst_n === 1'b0 && cs_n === 1'b1 && sclk === 1'b0 &&
            busy === 1'b0 && active === 1'b0, "R11 reset state",
            {supply_en, panel_rst_n, cs_n, sclk, busy, active}, 6'b001000);

        // R9 disable while idle, R10 gamma while idle
        fb = nfr;
        strobe(1);
        repeat (50) @(negedge clk);
        chk(nfr == fb && supply_en === 1'b0 && busy === 1'b0, "R9 disable ignored when idle",
            nfr - fb, 0);
        strobe(2);
        repeat (50) @(negedge clk);
        chk(nfr == fb && supply_en === 1'b0 && busy === 1'b0, "R10 gamma ignored when idle",
            nfr - fb, 0);

        // table walk
        for (int n = 0; n < 4; n++) begin
            mode_i = VEC[n][2:0]; hmir_i = VEC[n][3]; vmir_i = VEC[n][4];
            load_gamma(VEC[n][5]);
            power_up_and_check(VEC[n][2:0], VEC[n][3], VEC[n][4], VEC[n][5], 1'b0);
            power_down_and_check();
        end

        // R12 capture with inputs disturbed, plus R9 strobes mid-sequence
        mode_i = 3'd2; hmir_i = 1'b0; vmir_i = 1'b1; load_gamma(1'b0);
        power_up_and_check(3'd2, 1'b0, 1'b1, 1'b0, 1'b1);

        // R9 enable while active
        fb = nfr;
        strobe(0);
        repeat (200) @(negedge clk);
        chk(nfr == fb && active === 1'b1 && panel_rst_n === 1'b1, "R9 enable ignored when active",
            nfr - fb, 0);

        // R10 gamma replay
        load_gamma(1'b1);
        fb = nfr;
        strobe(2);
        chk(busy === 1'b1 && active === 1'b0, "R10 busy during replay", {busy, active}, 2'b10);
        load_gamma(1'b0);
        wait_active();
        chk(nfr - fb == 15, "R10 replay word count", nfr - fb, 15);
        for (int k = 0; k < 15; k++)
            chk(frm[fb+k] === exp_word(k + 5, 3'd0, 1'b0, 1'b0, 1'b1), "R10 replay word",
                frm[fb+k], exp_word(k + 5, 3'd0, 1'b0, 1'b0, 1'b1));
        chk(active === 1'b1 && supply_en === 1'b1, "R10 active after replay",
            {active, supply_en}, 2'b11);

        power_down_and_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule